// File: doc/BRIEF.md
# Transistor Current-Gain Measurement Controller

This block runs one current-gain measurement each time it is started. It steers an external 8-bit ADC through a one-bit channel select. It first converts the drive-voltage reference and then the reading at the collector resistor. It waits a fixed settling time after each channel change, and each conversion uses a start/end-of-conversion handshake.

The collector reading is turned into a voltage drop by subtracting it from full scale. That drop is multiplied by ten and divided by the reference, using a 16-cycle restoring divider. The result is limited to 8 bits. A low-gain alarm compares it with a threshold of 20. Two seven-segment outputs show the result as hexadecimal digits. A one-cycle done pulse marks the point where the new result, alarm, error flag and segment patterns appear.

The controller moves through five states:
- IDLE → SETTLE when start is seen.
- SETTLE → CONV when the settle count expires.
- CONV → WAIT unconditionally.
- WAIT → SETTLE when end-of-conversion arrives for the first sample.
- WAIT → DIVIDE when end-of-conversion arrives for the second sample.
- DIVIDE → IDLE when the divider finishes.

Top module: `gain_probe`

## Requirements
- R1: After reset, chan_sel, adc_start, done, alarm and ref_err are 0, and the held result is 0, so both segment outputs show the digit 0 (7'h3F).
- R2: When start is sampled high in IDLE, chan_sel is 1 from the next cycle. adc_start is then high for exactly one cycle, in the 11th cycle after the start edge, which allows 10 settle cycles.
- R3: The first sample is taken with chan_sel=1 and is the reference. It is captured at the first clock edge where adc_eoc is high after the pulse. chan_sel then drops to 0, and after another 10 settle cycles a second one-cycle adc_start pulse converts the collector channel.
- R4: The gain is floor((255 − collector) × 10 / reference). If the quotient exceeds 255, the result is 0xFF.
- R5: If the reference sample is 0, the result is 0xFF, ref_err is 1 and alarm is 0. Otherwise ref_err is 0.
- R6: With a nonzero reference, alarm is 1 exactly when the result is below 20. A result of 20 or more gives alarm 0.
- R7: seg_hi shows the upper nibble of the result and seg_lo the lower nibble. Both are active-high in gfedcba bit order, with 0..F = 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).
- R8: done is high for one cycle, 18 cycles after the edge that captures the collector sample. The result, alarm, ref_err and segments take their new values in that cycle and hold them until the next done.
- R9: start is ignored while a measurement is in progress; the timing of the running measurement is unchanged.
- R10: Each measurement produces exactly two adc_start pulses, each one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (acted on in IDLE) |
| adc_eoc | input | 1 | ADC end of conversion |
| adc_data | input | 8 | ADC conversion result |
| adc_start | output | 1 | One-cycle ADC conversion start |
| chan_sel | output | 1 | ADC channel: 1 reference, 0 collector |
| alarm | output | 1 | Gain below threshold |
| ref_err | output | 1 | Reference sample was zero |
| seg_hi | output | 7 | Upper hex digit, gfedcba |
| seg_lo | output | 7 | Lower hex digit, gfedcba |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Edges are counted from the one that samples start. chan_sel is due one cycle later. The first adc_start is due in cycle 11, and each capture happens at the first edge with end-of-conversion high. The second pulse comes 10 cycles after the first capture, and done with its results arrives 18 cycles after the second capture. The bench plays the ADC with its own chosen latencies and derives these cycle numbers from them. On every falling edge it compares adc_start, chan_sel, done and the held outputs with that timeline, so every result is checked in its own cycle and every hold interval is checked in full.

// File: rtl/gp_pkg.sv
package gp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_CONV,
        S_WAIT,
        S_DIVIDE
    } gp_state_t;

    // Hex nibble to active-high gfedcba segment pattern.
    function automatic logic [6:0] hex7(input logic [3:0] v);
        logic [6:0] s;
        unique case (v)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gp_divider.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module gp_divider #(
    parameter int NW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [NW-1:0] quo,
    output logic          fin
);
    localparam int KW = $clog2(NW + 1);

    logic [KW-1:0] steps;
    logic [DW-1:0] rem;
    logic [DW:0]   trial;
    logic          fits;

    assign trial = {rem, quo[NW-1]};
    assign fits  = trial >= {1'b0, divisor};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo   <= '0;
            rem   <= '0;
            steps <= '0;
            fin   <= 1'b0;
        end else if (go) begin
            quo   <= dividend;
            rem   <= '0;
            steps <= KW'(NW);
            fin   <= 1'b0;
        end else if (steps != '0) begin
            rem   <= fits ? DW'(trial - {1'b0, divisor}) : trial[DW-1:0];
            quo   <= {quo[NW-2:0], fits};
            steps <= steps - 1'b1;
            fin   <= (steps == KW'(1));
        end else begin
            fin   <= 1'b0;
        end
    end
endmodule

// File: rtl/gp_hex7.sv
module gp_hex7 (
    input  logic [3:0] nib,
    output logic [6:0] seg
);
    import gp_pkg::*;
    assign seg = hex7(nib);
endmodule

// File: rtl/gain_probe.sv
module gain_probe #(
    parameter int DW         = 8,
    parameter int SETTLE_CYC = 10,
    parameter int GAIN_SCALE = 10,
    parameter int LOW_GAIN   = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          adc_eoc,
    input  logic [DW-1:0] adc_data,
    output logic          adc_start,
    output logic          chan_sel,
    output logic          alarm,
    output logic          ref_err,
    output logic [6:0]    seg_hi,
    output logic [6:0]    seg_lo,
    output logic          done
);
    import gp_pkg::*;

    localparam int PW   = 2 * DW;
    localparam int CW   = $clog2(SETTLE_CYC + 1);
    localparam int NDIG = DW / 4;

    gp_state_t     state, nxt;
    logic [CW-1:0] set_cnt;
    logic          second;
    logic [DW-1:0] ref_q, coll_q, result;
    logic          div_go, div_fin;
    logic [PW-1:0] dividend, quo;
    logic [DW-1:0] gain_c;
    logic [6:0]    segs [NDIG];

    assign dividend  = PW'({DW{1'b1}} - coll_q) * PW'(GAIN_SCALE);
    assign gain_c    = ((ref_q == '0) || (|quo[PW-1:DW])) ? '1 : quo[DW-1:0];
    assign adc_start = (state == S_CONV);

    gp_divider #(.NW(PW), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(dividend), .divisor(ref_q),
        .quo(quo), .fin(div_fin)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_dig
            gp_hex7 u_hex (.nib(result[4*gi +: 4]), .seg(segs[gi]));
        end
    endgenerate
    assign seg_lo = segs[0];
    assign seg_hi = segs[NDIG-1];

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_SETTLE;
            S_SETTLE: if (set_cnt == CW'(SETTLE_CYC - 1)) nxt = S_CONV;
            S_CONV:   nxt = S_WAIT;
            S_WAIT:   if (adc_eoc) nxt = second ? S_DIVIDE : S_SETTLE;
            S_DIVIDE: if (div_fin) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_sel <= 1'b0;
            set_cnt  <= '0;
            second   <= 1'b0;
            ref_q    <= '0;
            coll_q   <= '0;
            div_go   <= 1'b0;
            result   <= '0;
            alarm    <= 1'b0;
            ref_err  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done   <= 1'b0;
            div_go <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        chan_sel <= 1'b1;
                        second   <= 1'b0;
                        set_cnt  <= '0;
                    end
                end
                S_SETTLE: set_cnt <= set_cnt + 1'b1;
                S_WAIT: begin
                    if (adc_eoc) begin
                        if (!second) begin
                            ref_q    <= adc_data;
                            second   <= 1'b1;
                            chan_sel <= 1'b0;
                            set_cnt  <= '0;
                        end else begin
                            coll_q   <= adc_data;
                            div_go   <= 1'b1;
                        end
                    end
                end
                S_DIVIDE: begin
                    if (div_fin) begin
                        done    <= 1'b1;
                        result  <= gain_c;
                        ref_err <= (ref_q == '0);
                        alarm   <= (ref_q != '0) && (gain_c < DW'(LOW_GAIN));
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gain_probe_chk.sv
module gain_probe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_start,
    input logic       chan_sel,
    input logic       alarm,
    input logic       ref_err,
    input logic [6:0] seg_hi,
    input logic [6:0] seg_lo,
    input logic       done
);
    p_adc_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({seg_hi, seg_lo, alarm, ref_err}));

    p_err_no_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_err |-> !alarm);

    p_alarm_low_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (seg_hi == 7'h3F || seg_hi == 7'h06));

    p_chan_settled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $stable(chan_sel));
endmodule

bind gain_probe gain_probe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .chan_sel(chan_sel),
    .alarm(alarm), .ref_err(ref_err), .seg_hi(seg_hi), .seg_lo(seg_lo),
    .done(done)
);

// File: tb/gain_probe_tb.sv
`timescale 1ns/1ps
module gain_probe_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       adc_eoc = 1'b0;
    logic [7:0] adc_data = 8'h00;
    logic       adc_start, chan_sel, alarm, ref_err, done;
    logic [6:0] seg_hi, seg_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Held expectations
    int exp_res = 0;
    bit exp_alarm = 0;
    bit exp_err = 0;

    always #2.5 clk = ~clk;

    gain_probe u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_eoc(adc_eoc),
        .adc_data(adc_data), .adc_start(adc_start), .chan_sel(chan_sel),
        .alarm(alarm), .ref_err(ref_err), .seg_hi(seg_hi), .seg_lo(seg_lo),
        .done(done)
    );

    function automatic int seg_of(input int v);
        case (v & 15)
            0: return 'h3F;  1: return 'h06;  2: return 'h5B;  3: return 'h4F;
            4: return 'h66;  5: return 'h6D;  6: return 'h7D;  7: return 'h07;
            8: return 'h7F;  9: return 'h6F;  10: return 'h77; 11: return 'h7C;
            12: return 'h39; 13: return 'h5E; 14: return 'h79; default: return 'h71;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_held(input string req);
        chk(seg_hi == 7'(seg_of(exp_res >> 4)), req, "seg_hi", seg_hi, seg_of(exp_res >> 4));
        chk(seg_lo == 7'(seg_of(exp_res)), "R7", "seg_lo", seg_lo, seg_of(exp_res));
        chk(alarm == exp_alarm, "R6", "alarm", alarm, exp_alarm);
        chk(ref_err == exp_err, "R5", "ref_err", ref_err, exp_err);
    endtask

    // One measurement: reference value, collector value, ADC latencies,
    // and an optional extra start pulse while busy.
    task automatic measure(input int rv, input int cv, input int l1, input int l2,
                           input bit poke);
        int t1, t2, tdone, q, nres;
        bit nal, nerr;
        string ttag;
        t1 = 11 + l1;
        t2 = t1 + 11 + l2;
        tdone = t2 + 18;
        ttag = poke ? "R9" : "R2";
        if (rv == 0) begin
            nres = 255; nerr = 1; nal = 0;
        end else begin
            q = ((255 - cv) * 10) / rv;
            nres = (q > 255) ? 255 : q;
            nerr = 0;
            nal = (nres < 20);
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;   // now after edge 0
        for (int n = 0; n <= tdone + 3; n++) begin
            // ADC model on the bench's own timeline
            if (n == 10 || n == t1 + 10) adc_eoc = 1'b0;
            if (n == 10 + l1) begin adc_eoc = 1'b1; adc_data = 8'(rv); end
            if (n == t1 + 10 + l2) begin adc_eoc = 1'b1; adc_data = 8'(cv); end
            if (poke) start = (n == 20 || n == t1 + 5);
            chk(adc_start == (n == 10 || n == t1 + 10), (n > t1) ? "R10" : ttag,
                "adc_start", adc_start, (n == 10 || n == t1 + 10));
            chk(chan_sel == (n < t1), (n < t1) ? ttag : "R3", "chan_sel",
                chan_sel, (n < t1));
            chk(done == (n == tdone), "R8", "done", done, (n == tdone));
            if (n == tdone) begin
                exp_res = nres; exp_alarm = nal; exp_err = nerr;
                chk_held("R4");
            end else begin
                chk_held("R8");
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(adc_start == 0, "R1", "adc_start", adc_start, 0);
        chk(chan_sel == 0, "R1", "chan_sel", chan_sel, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk_held("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_held("R1");

        measure(8, 155, 1, 3, 0);    // R4: 1000/8 = 125 (0x7D)
        measure(50, 200, 2, 1, 1);   // R6: 550/50 = 11 alarm, R9 start ignored
        measure(0, 100, 1, 1, 0);    // R5: zero reference
        measure(1, 0, 4, 2, 0);      // R4: 2550 saturates to 0xFF
        measure(10, 235, 1, 1, 0);   // R6: exactly 20, no alarm
        measure(10, 236, 3, 5, 0);   // R6: 19, alarm
        measure(255, 255, 1, 1, 0);  // R7: result 0x00
        measure(10, 0, 2, 2, 0);     // R4: exactly 255, not flagged
        measure(7, 13, 1, 6, 0);     // R7: 2420/7 -> saturated, then digits
        measure(200, 55, 1, 1, 0);   // R4: 2000/200 = 10 (0x0A)

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule